// File: doc/BRIEF.md
# Latched Fault Protection Supervisor

This block sits between the fault detectors of a four-bridge motor driver and the gate drivers. It receives, as digital flags already synchronised to its clock, one current-limit flag per power switch (four switches per bridge), an overtemperature flag and an undervoltage flag. It also receives a power-on reset, an active-low reset and an active-low sleep input. From these it produces a single enable that gates every bridge output, a request that clears the control registers, and three status flags that name the fault behind the present shutdown.

The fault classes recover differently. A current-limit flag must persist for a programmable number of clock cycles before it counts. The default is 150 cycles, which is 3 µs at 50 MHz. Once it counts, it latches a shutdown that only a power-on reset removes. An overtemperature flag latches in the same way. Undervoltage holds the outputs off and clears the control registers only while it is present, and operation resumes on its own when it goes away. Sleep turns the outputs off but leaves the control registers untouched.

Top module: `fault_supervisor`

## Requirements
- R1: While `por` is high, `drv_en`=0, `regs_clr`=1, `stat_oc`=0 and `stat_ot`=0, and both fault latches and the persistence timer are cleared asynchronously.
- R2: If any bit of `oc_flag` is high at `OC_HOLD_CYC` consecutive rising clock edges, `stat_oc` becomes 1 after the last of those edges, and `drv_en` is 0 from then on.
- R3: A current-limit episode covering fewer than `OC_HOLD_CYC` consecutive edges sets nothing. A single edge with all `oc_flag` bits low restarts the count, so two short episodes separated by that edge never add up.
- R4: A latched current-limit fault stays set when the flag clears, when `rst_n` pulses low, when sleep toggles and when undervoltage comes and goes. Only `por` clears it.
- R5: `ot_flag`=1 forces `drv_en`=0 in the same cycle, and `stat_ot` becomes 1 after the next edge. `stat_ot` stays 1 after the flag clears, until `por`. If the flag is still high when `por` is released, the fault latches again.
- R6: While `uv_flag`=1: `drv_en`=0, `regs_clr`=1 and `stat_uv`=1. When it drops, the outputs return without any further action, and the latches are unaffected.
- R7: While `rst_n`=0: `drv_en`=0 and `regs_clr`=1.
- R8: While `sleep_n`=0: `drv_en`=0. If there is no other clear source (`por`, `rst_n`=0, undervoltage), `regs_clr` stays 0.
- R9: `drv_en`=1 exactly when all of the following hold: `por` is low, `rst_n` and `sleep_n` are high, `uv_flag` and `ot_flag` are low, and neither latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por | input | 1 | Power-on reset, active high, asynchronous; marks a supply cycle |
| rst_n | input | 1 | Active-low reset of outputs and control registers |
| sleep_n | input | 1 | Active-low sleep; outputs off, registers kept |
| oc_flag | input | N_SW | Per-switch current-limit flags |
| ot_flag | input | 1 | Die overtemperature flag |
| uv_flag | input | 1 | Motor supply undervoltage flag |
| drv_en | output | 1 | Global enable for all bridge outputs |
| regs_clr | output | 1 | Request to return control registers to reset values |
| stat_oc | output | 1 | Latched current-limit shutdown |
| stat_ot | output | 1 | Latched overtemperature shutdown |
| stat_uv | output | 1 | Undervoltage present |

## Verification
The assertions assume that every flag input is already synchronous to `clk`. They also assume that `por` is high at time zero and is released away from a clock edge. The stimulus changes every input a fixed delay after a rising edge and holds `por` high for the first cycles. Current-limit episodes are driven on several different switch bits. Their lengths are one edge short of, equal to and longer than the persistence count, so both sides of the latch boundary are covered. Overtemperature is held across a `por` release to exercise the re-latch case.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int N_SW        = 16,
  parameter int OC_HOLD_CYC = 150
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst_n,
  input  logic            sleep_n,
  input  logic [N_SW-1:0] oc_flag,
  input  logic            ot_flag,
  input  logic            uv_flag,
  output logic            drv_en,
  output logic            regs_clr,
  output logic            stat_oc,
  output logic            stat_ot,
  output logic            stat_uv
);
  localparam int CW = $clog2(OC_HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_HOLD_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(OC_HOLD_CYC);

  logic [CW-1:0] oc_cnt;
  logic          oc_lat, ot_lat;
  logic          any_oc;

  assign any_oc = |oc_flag;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      oc_cnt <= '0;
      oc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      if (any_oc) begin
        if (oc_cnt != FULL) oc_cnt <= oc_cnt + 1'b1;
        if (oc_cnt == LAST) oc_lat <= 1'b1;
      end else begin
        oc_cnt <= '0;
      end
      if (ot_flag) ot_lat <= 1'b1;
    end
  end

  assign regs_clr = por | ~rst_n | uv_flag;
  assign drv_en   = ~regs_clr & sleep_n & ~ot_flag & ~oc_lat & ~ot_lat;
  assign stat_oc  = oc_lat;
  assign stat_ot  = ot_lat;
  assign stat_uv  = uv_flag;
endmodule

module fault_supervisor_chk #(
  parameter int N_SW = 16
) (
  input logic            clk,
  input logic            por,
  input logic            rst_n,
  input logic            sleep_n,
  input logic [N_SW-1:0] oc_flag,
  input logic            ot_flag,
  input logic            uv_flag,
  input logic            drv_en,
  input logic            regs_clr,
  input logic            stat_oc,
  input logic            stat_ot,
  input logic            stat_uv
);
  p_por_state_r1: assert property (@(posedge clk)
    por |-> (!drv_en && regs_clr && !stat_oc && !stat_ot));
  p_oc_gates_r2: assert property (@(posedge clk) disable iff (por)
    stat_oc |-> !drv_en);
  p_oc_cause_r3: assert property (@(posedge clk) disable iff (por)
    $rose(stat_oc) |-> $past(|oc_flag));
  p_oc_hold_r4: assert property (@(posedge clk) disable iff (por)
    stat_oc |=> stat_oc);
  p_ot_latch_r5: assert property (@(posedge clk) disable iff (por)
    ot_flag |=> stat_ot);
  p_ot_hold_r5: assert property (@(posedge clk) disable iff (por)
    stat_ot |=> stat_ot);
  p_uv_off_r6: assert property (@(posedge clk) disable iff (por)
    uv_flag |-> (!drv_en && regs_clr && stat_uv));
  p_rst_off_r7: assert property (@(posedge clk) disable iff (por)
    !rst_n |-> (!drv_en && regs_clr));
  p_sleep_off_r8: assert property (@(posedge clk) disable iff (por)
    !sleep_n |-> !drv_en);
  p_sleep_keep_r8: assert property (@(posedge clk) disable iff (por)
    (!sleep_n && rst_n && !uv_flag) |-> !regs_clr);
endmodule

bind fault_supervisor fault_supervisor_chk #(.N_SW(N_SW)) u_chk (.*);

// File: tb/fault_supervisor_bench.sv
`timescale 1ns/1ps
module fault_supervisor_bench;
  localparam int N_SW = 16;
  localparam int HOLD = 150;

  logic clk = 1'b0;
  logic por = 1'b1, rst_n = 1'b1, sleep_n = 1'b1, ot_flag = 1'b0, uv_flag = 1'b0;
  logic [N_SW-1:0] oc_flag = '0;
  logic drv_en, regs_clr, stat_oc, stat_ot, stat_uv;

  always #10 clk = ~clk;

  fault_supervisor #(.N_SW(N_SW), .OC_HOLD_CYC(HOLD)) u_fault_supervisor (
    .clk(clk), .por(por), .rst_n(rst_n), .sleep_n(sleep_n), .oc_flag(oc_flag),
    .ot_flag(ot_flag), .uv_flag(uv_flag), .drv_en(drv_en), .regs_clr(regs_clr),
    .stat_oc(stat_oc), .stat_ot(stat_ot), .stat_uv(stat_uv));

  typedef struct packed { logic en, clr, oc, ot, uv; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int m_cnt = 0;
  bit m_oc = 0, m_ot = 0;

  task automatic step(input bit p, input bit r, input bit s, input logic [N_SW-1:0] oc,
                      input bit ot, input bit uv, input string tag);
    exp_t e;
    @(posedge clk);
    #5;
    por = p; rst_n = r; sleep_n = s; oc_flag = oc; ot_flag = ot; uv_flag = uv;
    if (p) begin m_cnt = 0; m_oc = 0; m_ot = 0; end
    e.clr = p || !r || uv;
    e.en  = !e.clr && s && !ot && !m_oc && !m_ot;
    e.oc  = m_oc;
    e.ot  = m_ot;
    e.uv  = uv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (!p) begin
      if (oc != '0) begin
        if (m_cnt == HOLD - 1) m_oc = 1;
        if (m_cnt < HOLD) m_cnt++;
      end else m_cnt = 0;
      if (ot) m_ot = 1;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 1, 1, '0, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    exp_t a;
    string t;
    forever begin
      @(posedge clk);
      #15;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{drv_en, regs_clr, stat_oc, stat_ot, stat_uv};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got en/clr/oc/ot/uv=%b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 3; i++) step(1, 1, 1, '0, 0, 0, "R1 por");
    idle(2, "R9 enabled");
    for (int i = 0; i < HOLD - 1; i++) step(0, 1, 1, 16'h0008, 0, 0, "R3 short pulse a");
    step(0, 1, 1, '0, 0, 0, "R3 gap");
    for (int i = 0; i < HOLD - 1; i++) step(0, 1, 1, 16'h0400, 0, 0, "R3 short pulse b");
    idle(2, "R3 no latch");
    step(0, 1, 0, '0, 0, 0, "R8 sleep");
    step(0, 1, 0, '0, 0, 0, "R8 sleep");
    idle(1, "R8 wake");
    step(0, 0, 1, '0, 0, 0, "R7 reset");
    step(0, 0, 0, '0, 0, 0, "R7 reset with sleep");
    idle(1, "R7 release");
    for (int i = 0; i < 3; i++) step(0, 1, 1, '0, 0, 1, "R6 undervoltage");
    idle(2, "R6 resume");
    for (int i = 0; i < HOLD + 2; i++) step(0, 1, 1, 16'h0001, 0, 0, "R2 long overcurrent");
    idle(2, "R4 flag cleared");
    step(0, 0, 1, '0, 0, 0, "R4 reset pulse");
    step(0, 1, 0, '0, 0, 0, "R4 sleep toggle");
    step(0, 1, 1, '0, 0, 1, "R4 undervoltage");
    idle(2, "R4 still latched");
    step(1, 1, 1, '0, 0, 0, "R1 power cycle");
    step(1, 1, 1, '0, 0, 0, "R1 power cycle");
    idle(2, "R4 cleared by por");
    for (int i = 0; i < HOLD; i++) step(0, 1, 1, 16'h8000, 0, 0, "R2 exact hold");
    idle(2, "R2 latched at boundary");
    step(1, 1, 1, '0, 0, 0, "R1 por");
    idle(1, "R9 enabled");
    for (int i = 0; i < 3; i++) step(0, 1, 1, '0, 1, 0, "R5 overtemp");
    idle(2, "R5 latched after clear");
    step(1, 1, 1, '0, 1, 0, "R5 por with hot die");
    step(1, 1, 1, '0, 1, 0, "R5 por with hot die");
    step(0, 1, 1, '0, 1, 0, "R5 relatch");
    step(0, 1, 1, '0, 0, 0, "R5 relatched");
    step(1, 1, 1, '0, 0, 0, "R5 cool power cycle");
    idle(3, "R9 back to enabled");
    @(posedge clk);
    #20;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule